// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out where an 8-bit microcontroller core goes next once it has decoded an instruction. The core presents the address of the current instruction, its length in bytes (1 to 3), the opcode, up to two operand bytes, the accumulator, the 16-bit data pointer and a flag from the condition logic saying whether a conditional branch is taken. One clock later the block returns the next program counter. For the two constant-table read instructions it also returns the code-memory address to read.

The supported flows are:

- sequential advance;
- short relative jumps and conditional relative branches, with the offset taken from the address of the following instruction;
- jumps and calls within a 2 KB page;
- long 16-bit jumps and calls;
- the indirect jump through accumulator plus data pointer.

Pushing return addresses and fetching instructions belong to other blocks. Every opcode that is not listed in the requirements gives the sequential address, including the return opcodes, whose target comes from the stack logic.

All sums wrap modulo 2^16. The outputs are registered, and a transaction is marked by a one-cycle valid strobe.

Top module: `pc_target_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `lut_en` are 0, and `next_pc` and `lut_addr` are 0x0000.
- R2: For an opcode with no flow effect (for example 0x00 or 0x75), `next_pc` equals `cur_pc + ins_len`. The result is registered: it appears on the clock edge after the one that samples `in_valid` = 1.
- R3: For opcode 0x80 the target is `cur_pc + ins_len` plus the sign-extended offset. The offset is the last operand byte: `opnd1` when `ins_len` = 2 and `opnd2` when `ins_len` = 3.
- R4: The conditional relative branches are opcodes 0x10, 0x20, 0x30, 0x40, 0x50, 0x60, 0x70, 0xB4 to 0xBF, 0xD5 and 0xD8 to 0xDF. With `cond_taken` = 1 they go to the R3 target. With `cond_taken` = 0 they go to `cur_pc + ins_len`.
- R5: A page-absolute jump or call has `opcode[4:0]` = 00001 or 10001. Its target is {`(cur_pc+ins_len)[15:11]`, `opcode[7:5]`, `opnd1`}.
- R6: Opcodes 0x02 and 0x12 go to {`opnd1`, `opnd2`}, with `opnd1` as the high byte.
- R7: Opcode 0x73 goes to `dptr + acc`, with `acc` zero-extended.
- R8: Opcode 0x93 sets `lut_en` = 1 and `lut_addr` = `dptr + acc`. Opcode 0x83 sets `lut_en` = 1 and `lut_addr` = `cur_pc + ins_len + acc`. Both give `next_pc` = `cur_pc + ins_len`. For any other opcode `lut_en` is 0 and `lut_addr` is held.
- R9: Every address sum wraps modulo 2^16.
- R10: In a cycle with `in_valid` = 0, the next edge gives `out_valid` = 0 and `lut_en` = 0, and holds `next_pc` and `lut_addr`.
- R11: The short jump, page-absolute and long forms ignore `cond_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The instruction fields are valid this cycle |
| cur_pc | input | 16 | Address of the current instruction |
| ins_len | input | 2 | Instruction length in bytes, 1 to 3 |
| opcode | input | 8 | Opcode byte |
| opnd1 | input | 8 | First operand byte |
| opnd2 | input | 8 | Second operand byte |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| cond_taken | input | 1 | The branch condition holds |
| out_valid | output | 1 | `next_pc` has been updated this cycle |
| next_pc | output | 16 | Next program counter |
| lut_en | output | 1 | A table read is requested this cycle |
| lut_addr | output | 16 | Code address for the table read |

## Verification
The hardest cases to reach are the ones where the following-instruction address differs from the current one in a bit that matters. Two examples are a page-absolute jump whose own address is in one 2 KB page while the next address is in the following page, and a relative or table sum that crosses 0xFFFF. The stimulus places instructions at addresses just below those boundaries, such as 0x37FE, 0xFFF0 and 0xFFFE. Offsets are chosen so that a design using the current address instead of the following one, or taking the wrong operand byte as the offset, gives a visibly different result. Conditional branches are run with the flag both set and clear, and unconditional forms are run with the flag in the "wrong" state.

// File: rtl/pct_pkg.sv
package pct_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2;

  typedef enum logic [2:0] {
    FLOW_SEQ    = 3'd0,
    FLOW_REL    = 3'd1,
    FLOW_COND   = 3'd2,
    FLOW_PAGE   = 3'd3,
    FLOW_LONG   = 3'd4,
    FLOW_IND    = 3'd5,
    FLOW_LUT_DP = 3'd6,
    FLOW_LUT_PC = 3'd7
  } flow_e;

endpackage

// File: rtl/pct_adder.sv
module pct_adder #(
  parameter int AW   = 16,
  parameter int BW   = 8,
  parameter bit SEXT = 1'b0
) (
  input  logic [AW-1:0] base,
  input  logic [BW-1:0] inc,
  output logic [AW-1:0] sum
);

  localparam int PAD = AW - BW;

  logic [AW-1:0] inc_ext;

  generate
    if (SEXT) begin : g_signed
      assign inc_ext = {{PAD{inc[BW-1]}}, inc};
    end else begin : g_unsigned
      assign inc_ext = {{PAD{1'b0}}, inc};
    end
  endgenerate

  // Keeping only AW bits is what makes the sum wrap modulo 2^AW.
  assign sum = base + inc_ext;

endmodule

// File: rtl/pct_decode.sv
module pct_decode
  import pct_pkg::*;
#(
  parameter int BW = pct_pkg::BYTE_W
) (
  input  logic [BW-1:0] opcode,
  output flow_e         flow
);

  always_comb begin
    flow = FLOW_SEQ;
    if (opcode[4:0] == 5'b00001 || opcode[4:0] == 5'b10001) begin
      flow = FLOW_PAGE;
    end else begin
      unique casez (opcode)
        8'h02, 8'h12:                   flow = FLOW_LONG;
        8'h80:                          flow = FLOW_REL;
        8'h10, 8'h20, 8'h30, 8'h40,
        8'h50, 8'h60, 8'h70:            flow = FLOW_COND;
        8'hB4, 8'hB5, 8'hB6, 8'hB7:     flow = FLOW_COND;
        8'b1011_1???:                   flow = FLOW_COND;
        8'hD5, 8'b1101_1???:            flow = FLOW_COND;
        8'h73:                          flow = FLOW_IND;
        8'h93:                          flow = FLOW_LUT_DP;
        8'h83:                          flow = FLOW_LUT_PC;
        default:                        flow = FLOW_SEQ;
      endcase
    end
  end

endmodule

// File: rtl/pct_select.sv
module pct_select
  import pct_pkg::*;
#(
  parameter int AW = pct_pkg::ADDR_W,
  parameter int BW = pct_pkg::BYTE_W,
  parameter int LW = pct_pkg::LEN_W
) (
  input  flow_e         flow,
  input  logic [AW-1:0] cur_pc,
  input  logic [LW-1:0] ins_len,
  input  logic [BW-1:0] opcode,
  input  logic [BW-1:0] opnd1,
  input  logic [BW-1:0] opnd2,
  input  logic [BW-1:0] acc,
  input  logic [AW-1:0] dptr,
  input  logic          cond_taken,
  output logic [AW-1:0] fall_pc,
  output logic [AW-1:0] pc_nxt,
  output logic [AW-1:0] lut_nxt,
  output logic          lut_req
);

  localparam int PAGE_W = 11;
  localparam int HI_W   = AW - PAGE_W;
  localparam int OPB_W  = PAGE_W - BW;

  logic [BW-1:0] rel_off;
  logic [AW-1:0] rel_pc;
  logic [AW-1:0] acc_dp;
  logic [AW-1:0] acc_pc;
  logic [AW-1:0] page_pc;

  pct_adder #(.AW(AW), .BW(LW), .SEXT(1'b0)) u_fall (
    .base(cur_pc), .inc(ins_len), .sum(fall_pc)
  );

  // The offset is always the last operand byte of the instruction.
  assign rel_off = (ins_len == LW'(3)) ? opnd2 : opnd1;

  pct_adder #(.AW(AW), .BW(BW), .SEXT(1'b1)) u_rel (
    .base(fall_pc), .inc(rel_off), .sum(rel_pc)
  );

  pct_adder #(.AW(AW), .BW(BW), .SEXT(1'b0)) u_accdp (
    .base(dptr), .inc(acc), .sum(acc_dp)
  );

  pct_adder #(.AW(AW), .BW(BW), .SEXT(1'b0)) u_accpc (
    .base(fall_pc), .inc(acc), .sum(acc_pc)
  );

  assign page_pc = {fall_pc[AW-1 -: HI_W], opcode[BW-1 -: OPB_W], opnd1};

  always_comb begin
    pc_nxt  = fall_pc;
    lut_nxt = acc_dp;
    lut_req = 1'b0;
    unique case (flow)
      FLOW_REL:    pc_nxt = rel_pc;
      FLOW_COND:   pc_nxt = cond_taken ? rel_pc : fall_pc;
      FLOW_PAGE:   pc_nxt = page_pc;
      FLOW_LONG:   pc_nxt = {opnd1, opnd2};
      FLOW_IND:    pc_nxt = acc_dp;
      FLOW_LUT_DP: begin lut_nxt = acc_dp; lut_req = 1'b1; end
      FLOW_LUT_PC: begin lut_nxt = acc_pc; lut_req = 1'b1; end
      default:     pc_nxt = fall_pc;
    endcase
  end

endmodule

// File: rtl/pc_target_unit.sv
module pc_target_unit
  import pct_pkg::*;
#(
  parameter int AW = pct_pkg::ADDR_W,
  parameter int BW = pct_pkg::BYTE_W,
  parameter int LW = pct_pkg::LEN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] cur_pc,
  input  logic [LW-1:0] ins_len,
  input  logic [BW-1:0] opcode,
  input  logic [BW-1:0] opnd1,
  input  logic [BW-1:0] opnd2,
  input  logic [BW-1:0] acc,
  input  logic [AW-1:0] dptr,
  input  logic          cond_taken,
  output logic          out_valid,
  output logic [AW-1:0] next_pc,
  output logic          lut_en,
  output logic [AW-1:0] lut_addr
);

  flow_e         flow;
  logic [AW-1:0] fall_pc;
  logic [AW-1:0] pc_nxt;
  logic [AW-1:0] lut_nxt;
  logic          lut_req;

  pct_decode #(.BW(BW)) u_dec (
    .opcode(opcode), .flow(flow)
  );

  pct_select #(.AW(AW), .BW(BW), .LW(LW)) u_sel (
    .flow(flow), .cur_pc(cur_pc), .ins_len(ins_len), .opcode(opcode),
    .opnd1(opnd1), .opnd2(opnd2), .acc(acc), .dptr(dptr),
    .cond_taken(cond_taken), .fall_pc(fall_pc), .pc_nxt(pc_nxt),
    .lut_nxt(lut_nxt), .lut_req(lut_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      lut_en    <= 1'b0;
      next_pc   <= '0;
      lut_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      lut_en    <= in_valid & lut_req;
      if (in_valid) begin
        next_pc <= pc_nxt;
        if (lut_req) lut_addr <= lut_nxt;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (out_valid == $past(in_valid))); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> ($stable(next_pc) && $stable(lut_addr) && !lut_en)); // R10

  AST_PAGE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flow == FLOW_PAGE) |=> (next_pc[AW-1:11] == $past(fall_pc[AW-1:11]))); // R5

  AST_LONG_DEST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flow == FLOW_LONG) |=> (next_pc == {$past(opnd1), $past(opnd2)})); // R6

  AST_LUT_DPTR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flow == FLOW_LUT_DP) |=>
      (lut_en && lut_addr == $past(dptr) + {{(AW-BW){1'b0}}, $past(acc)})); // R8

  AST_SEQ_ADV: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flow == FLOW_SEQ) |=>
      (next_pc == $past(cur_pc) + {{(AW-LW){1'b0}}, $past(ins_len)})); // R2

endmodule

// File: tb/pc_target_unit_test.sv
module pc_target_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] cur_pc;
  logic [1:0]  ins_len;
  logic [7:0]  opcode, opnd1, opnd2, acc;
  logic [15:0] dptr;
  logic        cond_taken;
  logic        out_valid;
  logic [15:0] next_pc;
  logic        lut_en;
  logic [15:0] lut_addr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pc_target_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc),
    .ins_len(ins_len), .opcode(opcode), .opnd1(opnd1), .opnd2(opnd2),
    .acc(acc), .dptr(dptr), .cond_taken(cond_taken), .out_valid(out_valid),
    .next_pc(next_pc), .lut_en(lut_en), .lut_addr(lut_addr)
  );

  // {pc, len, op, o1, o2, acc, dptr, taken, exp_pc, exp_lut, exp_lut_en}
  localparam int NV = 19;
  localparam logic [99:0] VEC [NV] = '{
    {16'h1234,2'd1,8'h00,8'h00,8'h00,8'h00,16'h0000,1'b0,16'h1235,16'h0000,1'b0}, // R2
    {16'h0100,2'd3,8'h75,8'h11,8'h22,8'h00,16'h0000,1'b1,16'h0103,16'h0000,1'b0}, // R2
    {16'h0200,2'd2,8'h80,8'h10,8'h99,8'h00,16'h0000,1'b0,16'h0212,16'h0000,1'b0}, // R3 R11
    {16'h0200,2'd2,8'h80,8'hFE,8'h00,8'h00,16'h0000,1'b0,16'h0200,16'h0000,1'b0}, // R3
    {16'h0300,2'd2,8'h60,8'h80,8'h00,8'h00,16'h0000,1'b1,16'h0282,16'h0000,1'b0}, // R4
    {16'h0300,2'd2,8'h60,8'h80,8'h00,8'h00,16'h0000,1'b0,16'h0302,16'h0000,1'b0}, // R4
    {16'h0400,2'd3,8'h20,8'h55,8'h7F,8'h00,16'h0000,1'b1,16'h0482,16'h0000,1'b0}, // R4
    {16'h0500,2'd3,8'hB4,8'h12,8'hF0,8'h00,16'h0000,1'b1,16'h04F3,16'h0000,1'b0}, // R4
    {16'h0600,2'd2,8'hD8,8'h05,8'hAA,8'h00,16'h0000,1'b1,16'h0607,16'h0000,1'b0}, // R4
    {16'h37FE,2'd2,8'hE1,8'h3C,8'h00,8'h00,16'h0000,1'b1,16'h3F3C,16'h0000,1'b0}, // R5
    {16'h8000,2'd2,8'h51,8'hAA,8'h00,8'h00,16'h0000,1'b0,16'h82AA,16'h0000,1'b0}, // R5 R11
    {16'h1000,2'd3,8'h02,8'hBE,8'hEF,8'h00,16'h0000,1'b0,16'hBEEF,16'h0000,1'b0}, // R6
    {16'h1000,2'd3,8'h12,8'h00,8'h03,8'h00,16'h0000,1'b1,16'h0003,16'h0000,1'b0}, // R6 R11
    {16'h0800,2'd1,8'h73,8'h00,8'h00,8'hF0,16'hFF20,1'b0,16'h0010,16'h0000,1'b0}, // R7 R9
    {16'h2000,2'd1,8'h93,8'h00,8'h00,8'h45,16'h1234,1'b0,16'h2001,16'h1279,1'b1}, // R8
    {16'h2000,2'd1,8'h83,8'h00,8'h00,8'hFF,16'h1234,1'b0,16'h2001,16'h2100,1'b1}, // R8
    {16'hFFFF,2'd1,8'h00,8'h00,8'h00,8'h00,16'h0000,1'b0,16'h0000,16'h0000,1'b0}, // R9
    {16'hFFF0,2'd2,8'h80,8'h20,8'h00,8'h00,16'h0000,1'b0,16'h0012,16'h0000,1'b0}, // R9
    {16'hFFFE,2'd1,8'h83,8'h00,8'h00,8'h05,16'h0000,1'b0,16'hFFFF,16'h0004,1'b1}  // R9
  };
  localparam int VREQ [NV] = '{2,2,3,3,4,4,4,4,4,5,5,6,6,7,8,8,9,9,9};

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [99:0] v);
    cur_pc     = v[99:84];
    ins_len    = v[83:82];
    opcode     = v[81:74];
    opnd1      = v[73:66];
    opnd2      = v[65:58];
    acc        = v[57:50];
    dptr       = v[49:34];
    cond_taken = v[33];
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] held_pc, held_lut;
    rst = 1'b1; in_valid = 1'b1;
    drive(VEC[14]);
    repeat (3) @(negedge clk);
    check1("R1 out_valid in reset", out_valid, 1'b0);
    check1("R1 lut_en in reset", lut_en, 1'b0);
    check16("R1 next_pc in reset", next_pc, 16'h0000);
    check16("R1 lut_addr in reset", lut_addr, 16'h0000);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check1("R1 out_valid after reset", out_valid, 1'b0);
    check16("R1 next_pc after reset", next_pc, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      check1($sformatf("R%0d vec %0d out_valid", VREQ[i], i), out_valid, 1'b1);
      check16($sformatf("R%0d vec %0d next_pc", VREQ[i], i), next_pc, VEC[i][32:17]);
      check1($sformatf("R%0d vec %0d lut_en", VREQ[i], i), lut_en, VEC[i][0]);
      if (VEC[i][0])
        check16($sformatf("R%0d vec %0d lut_addr", VREQ[i], i), lut_addr, VEC[i][16:1]);
    end

    // R8: a non-table opcode leaves lut_addr at its previous value (0x0004)
    drive(VEC[0]);
    @(negedge clk);
    check16("R8 lut_addr held on non-table op", lut_addr, 16'h0004);
    check1("R8 lut_en low on non-table op", lut_en, 1'b0);

    // R10: idle cycles hold state even with table opcode on the inputs
    held_pc = next_pc; held_lut = lut_addr;
    drive(VEC[15]);
    in_valid = 1'b0;
    @(negedge clk);
    check1("R10 out_valid idle", out_valid, 1'b0);
    check1("R10 lut_en idle", lut_en, 1'b0);
    check16("R10 next_pc held", next_pc, held_pc);
    check16("R10 lut_addr held", lut_addr, held_lut);
    drive(VEC[11]);
    @(negedge clk);
    check16("R10 next_pc held second idle", next_pc, held_pc);

    // R1: reset in the middle of activity
    in_valid = 1'b1;
    @(negedge clk);
    check16("R6 long before reset", next_pc, 16'hBEEF);
    rst = 1'b1;
    @(negedge clk);
    check16("R1 next_pc mid-run reset", next_pc, 16'h0000);
    check1("R1 out_valid mid-run reset", out_valid, 1'b0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule